// File: doc/BRIEF.md
# Register-Watch Loop Exit Trigger

This unit lets a program run a loop body with no compare-and-branch at its bottom. Before the loop starts, software installs a handler address and programs up to three exit conditions. Two of them watch the loop-counter register: it can reach a programmed limit, or it can become zero. The third watches a data register, which can match a programmed pattern. Any enabled condition is enough to end the loop. Software then sets a single arm bit.

The unit monitors the register file write port. It compares each value being written against the armed conditions, using the old register contents for nothing. When a condition hits, the unit raises a one-cycle redirect request in the next cycle. The request carries the handler address, the return PC that the pipeline should push, and a cause vector. The arm bit clears on firing, so each arming yields at most one redirect. Any configuration write while armed also disarms the unit. The pipeline flush, the stack and the address translation of the handler belong to neighbouring blocks.

Top module: `loopwatch_trigger`

## Requirements
- R1: After reset the unit is disarmed, and `redir_valid` and `redir_cause` are 0.
- R2: When armed with the limit condition enabled (control bit 1), a register-file write to the counter register (index in control bits [4+IDX_W-1:4]) whose data equals the limit value (config select 1) gives `redir_valid` high in the following cycle, with cause bit 0 set.
- R3: When armed with the match condition enabled (control bit 2), a write to the test register (index in control bits [4+2*IDX_W-1:4+IDX_W]) whose data equals the match value (config select 2) fires, with cause bit 1 set.
- R4: When armed with zero mode enabled (control bit 3), a write of 0 to the counter register fires, with cause bit 2 set.
- R5: No redirect occurs for any of the following: writes to other registers, non-matching data, disabled conditions, or a disarmed unit.
- R6: The arm bit (control bit 0) clears on firing, so a further hit before re-arming gives no redirect. `redir_valid` is high for exactly one cycle per firing.
- R7: If several conditions hit in the same write, exactly one redirect is issued, and its cause holds every bit that hit.
- R8: With the redirect, `redir_target` equals the handler address (config select 3), and `redir_ret_pc` equals the `rf_next_pc` presented with the triggering write.
- R9: Any configuration write while armed disarms the unit, including a control write with the arm bit set. A control write with bit 0 set while disarmed arms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target: 0 control, 1 limit, 2 match, 3 handler |
| cfg_wdata | input | CFG_W | Configuration write data |
| rf_we | input | 1 | Register-file write strobe |
| rf_waddr | input | IDX_W | Register-file write index |
| rf_wdata | input | DATA_W | Register-file write data |
| rf_next_pc | input | PC_W | Return PC belonging to the writing instruction |
| redir_valid | output | 1 | One-cycle redirect request |
| redir_target | output | PC_W | Handler address to redirect to |
| redir_ret_pc | output | PC_W | Return PC to be pushed |
| redir_cause | output | 3 | Conditions that hit: bit 0 limit, bit 1 match, bit 2 zero |

## Verification
Suppose the arm flag is wrong. A stuck-set flag shows as a second redirect pulse on the next qualifying write. A stuck-clear flag shows as a missing pulse one cycle after a hit. A wrong condition enable or register index shows as a pulse on the wrong write, or no pulse on the right one, in the cycle right after that write. Corrupted limit, match or handler storage shows in the first firing after configuration, either as a wrong firing value or as a wrong `redir_target`. The bench sweeps every data value against every limit and pattern, and every register index against every watched index, so each such fault appears within one write.

// File: rtl/loopwatch_pkg.sv
package loopwatch_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_LIMIT   = 2'd1,
        SEL_MATCH   = 2'd2,
        SEL_HANDLER = 2'd3
    } cfg_sel_e;

    localparam int NCOND      = 3;
    localparam int COND_LIMIT = 0;
    localparam int COND_MATCH = 1;
    localparam int COND_ZERO  = 2;

    localparam int CTRL_ARM    = 0;
    localparam int CTRL_EN_LO  = 1;
    localparam int CTRL_IDX_LO = 4;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/loopwatch_cfg.sv
module loopwatch_cfg
    import loopwatch_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    parameter int IDX_W  = 5,
    parameter int CFG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic              cfg_wr,
    output logic              arm_req,
    output logic [NCOND-1:0]  cond_en,
    output logic [IDX_W-1:0]  cnt_idx,
    output logic [IDX_W-1:0]  tst_idx,
    output logic [DATA_W-1:0] limit_val,
    output logic [DATA_W-1:0] match_val,
    output logic [PC_W-1:0]   handler
);

    localparam int TST_LO = CTRL_IDX_LO + IDX_W;

    typedef struct packed {
        logic [NCOND-1:0]  en;
        logic [IDX_W-1:0]  cnt;
        logic [IDX_W-1:0]  tst;
        logic [DATA_W-1:0] lim;
        logic [DATA_W-1:0] mat;
        logic [PC_W-1:0]   hnd;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    cfg_sel_e   sel;

    always_comb begin
        sel     = cfg_sel_e'(cfg_sel);
        st_d    = st_q;
        cfg_wr  = cfg_we;
        arm_req = 1'b0;
        if (cfg_we) begin
            case (sel)
                SEL_CTRL: begin
                    st_d.en = cfg_wdata[CTRL_EN_LO +: NCOND];
                    st_d.cnt = cfg_wdata[CTRL_IDX_LO +: IDX_W];
                    st_d.tst = cfg_wdata[TST_LO +: IDX_W];
                    arm_req  = cfg_wdata[CTRL_ARM];
                end
                SEL_LIMIT:   st_d.lim = cfg_wdata[DATA_W-1:0];
                SEL_MATCH:   st_d.mat = cfg_wdata[DATA_W-1:0];
                SEL_HANDLER: st_d.hnd = cfg_wdata[PC_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cond_en   = st_q.en;
    assign cnt_idx   = st_q.cnt;
    assign tst_idx   = st_q.tst;
    assign limit_val = st_q.lim;
    assign match_val = st_q.mat;
    assign handler   = st_q.hnd;

    AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_sel == SEL_LIMIT) |=> $stable(limit_val)); // R2

endmodule

// File: rtl/loopwatch_cmp.sv
module loopwatch_cmp
    import loopwatch_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rf_we,
    input  logic [IDX_W-1:0]  rf_waddr,
    input  logic [DATA_W-1:0] rf_wdata,
    input  logic [NCOND-1:0]  cond_en,
    input  logic [IDX_W-1:0]  cnt_idx,
    input  logic [IDX_W-1:0]  tst_idx,
    input  logic [DATA_W-1:0] limit_val,
    input  logic [DATA_W-1:0] match_val,
    output logic [NCOND-1:0]  hit
);

    for (genvar g = 0; g < NCOND; g++) begin : g_cond
        logic [IDX_W-1:0]  watch_idx;
        logic [DATA_W-1:0] ref_val;
        if (g == COND_MATCH) begin : g_tst
            assign watch_idx = tst_idx;
            assign ref_val   = match_val;
        end else if (g == COND_LIMIT) begin : g_lim
            assign watch_idx = cnt_idx;
            assign ref_val   = limit_val;
        end else begin : g_zero
            assign watch_idx = cnt_idx;
            assign ref_val   = '0;
        end
        assign hit[g] = cond_en[g] && rf_we && (rf_waddr == watch_idx)
                        && (rf_wdata == ref_val);
    end

    AST_HIT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !rf_we |-> (hit == '0)); // R5

endmodule

// File: rtl/loopwatch_fire.sv
module loopwatch_fire
    import loopwatch_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             arm_req,
    input  logic [NCOND-1:0] hit,
    input  logic [PC_W-1:0]  handler,
    input  logic [PC_W-1:0]  next_pc,
    output logic             redir_valid,
    output logic [PC_W-1:0]  redir_target,
    output logic [PC_W-1:0]  redir_ret_pc,
    output logic [NCOND-1:0] redir_cause
);

    typedef struct packed {
        logic             armed;
        logic             valid;
        logic [PC_W-1:0]  target;
        logic [PC_W-1:0]  ret;
        logic [NCOND-1:0] cause;
    } fire_state_t;

    fire_state_t st_d, st_q;
    logic        fire;

    always_comb begin
        st_d  = st_q;
        fire  = st_q.armed && (|hit);
        if (fire || (cfg_wr && st_q.armed)) st_d.armed = 1'b0;
        else if (arm_req)                   st_d.armed = 1'b1;
        st_d.valid = fire;
        st_d.cause = '0;
        if (fire) begin
            st_d.target = handler;
            st_d.ret    = next_pc;
            st_d.cause  = hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign redir_valid  = st_q.valid;
    assign redir_target = st_q.target;
    assign redir_ret_pc = st_q.ret;
    assign redir_cause  = st_q.cause;

    AST_FIRE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && |hit) |=> redir_valid); // R2
    AST_QUIET_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.armed |=> !redir_valid); // R5
    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> !st_q.armed); // R6
    AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (redir_cause != '0)); // R7
    AST_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> (redir_target == $past(handler))); // R8
    AST_CFG_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && st_q.armed) |=> !st_q.armed); // R9

endmodule

// File: rtl/loopwatch_trigger.sv
module loopwatch_trigger
    import loopwatch_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    parameter int IDX_W  = 5,
    localparam int CFG_W = max3(DATA_W, PC_W, CTRL_IDX_LO + 2 * IDX_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              rf_we,
    input  logic [IDX_W-1:0]  rf_waddr,
    input  logic [DATA_W-1:0] rf_wdata,
    input  logic [PC_W-1:0]   rf_next_pc,
    output logic              redir_valid,
    output logic [PC_W-1:0]   redir_target,
    output logic [PC_W-1:0]   redir_ret_pc,
    output logic [2:0]        redir_cause
);

    logic              cfg_wr, arm_req;
    logic [NCOND-1:0]  cond_en, hit;
    logic [IDX_W-1:0]  cnt_idx, tst_idx;
    logic [DATA_W-1:0] limit_val, match_val;
    logic [PC_W-1:0]   handler;

    loopwatch_cfg #(
        .DATA_W(DATA_W), .PC_W(PC_W), .IDX_W(IDX_W), .CFG_W(CFG_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_wr(cfg_wr), .arm_req(arm_req), .cond_en(cond_en),
        .cnt_idx(cnt_idx), .tst_idx(tst_idx),
        .limit_val(limit_val), .match_val(match_val), .handler(handler)
    );

    loopwatch_cmp #(
        .DATA_W(DATA_W), .IDX_W(IDX_W)
    ) u_cmp (
        .clk(clk), .rst_n(rst_n),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .cond_en(cond_en), .cnt_idx(cnt_idx), .tst_idx(tst_idx),
        .limit_val(limit_val), .match_val(match_val), .hit(hit)
    );

    loopwatch_fire #(
        .PC_W(PC_W)
    ) u_fire (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .arm_req(arm_req), .hit(hit),
        .handler(handler), .next_pc(rf_next_pc),
        .redir_valid(redir_valid), .redir_target(redir_target),
        .redir_ret_pc(redir_ret_pc), .redir_cause(redir_cause)
    );

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> !redir_valid); // R6

endmodule

// File: tb/loopwatch_trigger_test.sv
`timescale 1ns/1ps
module loopwatch_trigger_test;

    localparam int DW = 4;
    localparam int PW = 8;
    localparam int IW = 3;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [CW-1:0] cfg_wdata = '0;
    logic          rf_we = 1'b0;
    logic [IW-1:0] rf_waddr = '0;
    logic [DW-1:0] rf_wdata = '0;
    logic [PW-1:0] rf_next_pc = '0;
    logic          redir_valid;
    logic [PW-1:0] redir_target, redir_ret_pc;
    logic [2:0]    redir_cause;

    int checks = 0;
    int errors = 0;

    loopwatch_trigger #(.DATA_W(DW), .PC_W(PW), .IDX_W(IW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .rf_next_pc(rf_next_pc),
        .redir_valid(redir_valid), .redir_target(redir_target),
        .redir_ret_pc(redir_ret_pc), .redir_cause(redir_cause)
    );

    always #4 clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        summary();
    end

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    function automatic logic [CW-1:0] ctrl(input bit arm, input bit le,
            input bit me, input bit ze, input int ci, input int ti);
        logic [CW-1:0] w;
        w = '0;
        w[0] = arm; w[1] = le; w[2] = me; w[3] = ze;
        w[6:4] = ci[2:0];
        w[9:7] = ti[2:0];
        return w;
    endfunction

    task automatic cfg(input int sel, input logic [CW-1:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // write a register, then sample the redirect one edge later
    task automatic rfw(input int idx, input int val, input int pc,
            input string req, input bit exp_v, input int exp_c, input int exp_t);
        @(negedge clk);
        rf_we = 1'b1; rf_waddr = idx[IW-1:0]; rf_wdata = val[DW-1:0];
        rf_next_pc = pc[PW-1:0];
        @(negedge clk);
        rf_we = 1'b0;
        chk(req, int'(redir_valid), int'(exp_v));
        if (exp_v) begin
            chk(req, int'(redir_cause), exp_c);
            chk("R8 target", int'(redir_target), exp_t);
            chk("R8 retpc", int'(redir_ret_pc), pc & 8'hFF);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 valid", int'(redir_valid), 0);
        chk("R1 cause", int'(redir_cause), 0);
        rst_n = 1'b1;
        @(negedge clk);
        rfw(0, 0, 1, "R1 disarmed after reset", 0, 0, 0);

        // R2 limit sweep, counter reg 2; R6 one-shot after each hit
        for (int l = 0; l < 16; l++) begin
            cfg(3, CW'(8'h40 + l));
            cfg(1, CW'(l));
            cfg(0, ctrl(1, 1, 0, 0, 2, 5));
            for (int v = 0; v < 16; v++)
                rfw(2, v, v * 3 + l, "R2 limit", v == l, 1, 8'h40 + l);
            rfw(2, l, 9, "R6 no refire", 0, 0, 0);
        end

        // R3 match sweep, test reg 5; R5 writes to the counter reg ignored
        for (int m = 0; m < 16; m++) begin
            cfg(3, CW'(8'h80 + m));
            cfg(2, CW'(m));
            cfg(0, ctrl(1, 0, 1, 0, 2, 5));
            rfw(2, m, 3, "R5 other reg", 0, 0, 0);
            for (int v = 0; v < 16; v++)
                rfw(5, v, 200 - v, "R3 match", v == m, 2, 8'h80 + m);
        end

        // R4 zero mode counting down on reg 3
        cfg(3, CW'(8'hC4));
        cfg(1, CW'(7));
        cfg(0, ctrl(1, 0, 0, 1, 3, 6));
        for (int v = 15; v >= 0; v--)
            rfw(3, v, 100 + v, "R4 zero", v == 0, 4, 8'hC4);

        // R5 index sweep: only the watched index fires
        cfg(1, CW'(7));
        cfg(3, CW'(8'h11));
        for (int k = 0; k < 8; k++) begin
            cfg(0, ctrl(1, 1, 0, 0, k, 0));
            for (int j = 0; j < 8; j++)
                rfw(j, 7, j + 20, "R5 index", j == k, 1, 8'h11);
        end
        // R5 disabled condition and disarmed unit
        cfg(0, ctrl(1, 0, 1, 0, 1, 2));
        rfw(1, 7, 5, "R5 limit disabled", 0, 0, 0);
        cfg(0, ctrl(0, 0, 0, 0, 0, 0));
        cfg(0, ctrl(0, 1, 1, 1, 1, 1));
        rfw(1, 7, 5, "R5 disarmed", 0, 0, 0);
        rfw(1, 0, 5, "R5 disarmed zero", 0, 0, 0);

        // R7 simultaneous conditions
        cfg(1, CW'(9));
        cfg(2, CW'(9));
        cfg(3, CW'(8'h5A));
        cfg(0, ctrl(1, 1, 1, 0, 4, 4));
        rfw(4, 9, 77, "R7 limit+match", 1, 3, 8'h5A);
        rfw(4, 9, 78, "R7 single pulse", 0, 0, 0);
        cfg(1, CW'(0));
        cfg(0, ctrl(1, 1, 0, 1, 4, 4));
        rfw(4, 0, 79, "R7 limit+zero", 1, 5, 8'h5A);

        // R9 config write while armed disarms
        cfg(1, CW'(6));
        cfg(0, ctrl(1, 1, 0, 0, 2, 0));
        cfg(1, CW'(6));
        rfw(2, 6, 1, "R9 data write disarms", 0, 0, 0);
        cfg(0, ctrl(1, 1, 0, 0, 2, 0));
        cfg(0, ctrl(1, 1, 0, 0, 2, 0));
        rfw(2, 6, 1, "R9 ctrl write disarms", 0, 0, 0);
        cfg(0, ctrl(1, 1, 0, 0, 2, 0));
        rfw(2, 6, 42, "R9 rearm fires", 1, 1, 8'h5A);

        summary();
    end

endmodule